// File: doc/BRIEF.md
# Paged Memory Address Translator

The translator turns a 16-bit processor-local address into a 23-bit global address. The local space is split into fixed windows and paged windows. Fixed windows map to one set place in the global space. Paged windows take their upper address bits from one of three page registers: program-flash, data-flash or RAM. A separate global-access flag bypasses window decoding and joins a fourth page register to the full local address. Each result carries an illegal flag. The flag is raised when a paged window is used with a page number that decodes to no physical memory. The RAM page register resets to such a number, so any RAM-window access made before software sets up that register is trapped.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream. A request accepted at a clock edge gives its registered result right after that edge, so the latency is one cycle. A result is held until the consumer takes it. When the result slot is full and the consumer is stalling, the request side is not ready. The page registers are written and read through a plain register port. A request is translated with the page values that are in place before any write made at the same edge.

Top module: `paged_addr_xlate`

## Requirements
- R1: After reset, rsp_valid is 0 and the page registers read back as program 0xFE, data-flash 0x00, RAM 0xFD and global 0x00.
- R2: When the global flag is clear, local addresses 0x4000–0x7FFF and 0xC000–0xFFFF map to 0x7F0000 + local. These accesses are never illegal.
- R3: Local addresses 0x8000–0xBFFF map to {1'b1, program page[7:0], local[13:0]}. For example, page 0xFC gives 0x7F0000–0x7F3FFF. The access is illegal when the program page is below 0xF8.
- R4: Local addresses 0x0800–0x0BFF map to 0x100000 + data-flash page × 0x400 + local[9:0], and the access is illegal when that page is above 0x07. Local addresses 0x0C00–0x0FFF map to 0x101C00 + local[9:0] and are always legal.
- R5: Local addresses 0x1000–0x1FFF map to {3'b000, RAM page[7:0], local[11:0]}, and the access is illegal when the RAM page is below 0xFE. The reset value 0xFD therefore traps.
- R6: Local addresses 0x2000–0x3FFF map to 0x0FE000 + (local − 0x2000). These accesses are always legal.
- R7: Local addresses 0x0000–0x07FF, the register area, map to the local value with zero extension. These accesses are always legal.
- R8: When req_global is 1, the result is {global page[6:0], local[15:0]} for any local address, and it is never illegal.
- R9: The register select codes are 0 for program, 1 for data-flash, 2 for RAM and 3 for global. A write takes effect at the clock edge. reg_rdata always shows the stored value of the register picked by reg_rd_sel. Bit 7 of the global page always reads 0, and writes to that bit are ignored.
- R10: A request accepted at an edge shows on rsp_* directly after that edge. The translation uses the page values from before a page write made at that same edge.
- R11: req_ready equals (!rsp_valid || rsp_ready). While rsp_valid is 1 and rsp_ready is 0, rsp_gaddr and rsp_illegal stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_laddr | input | 16 | Local address |
| req_global | input | 1 | Global access: use the global page and skip window decoding |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_gaddr | output | 23 | Global address |
| rsp_illegal | output | 1 | The page used decodes to no memory |
| reg_wr_en | input | 1 | Page register write strobe |
| reg_sel | input | 2 | Register to write (0 program, 1 data-flash, 2 RAM, 3 global) |
| reg_wdata | input | 8 | Write data |
| reg_rd_sel | input | 2 | Register to read, same encoding |
| reg_rdata | output | 8 | Read data |

## Verification
The assertions assume that reset is held low for at least one edge and that req_valid is low while reset is held. They also assume that the consumer may stall for any length of time but never drops rsp_ready in the middle of an edge. The stimulus drives every input half a cycle away from the active edge. It keeps req_valid low during reset, and it holds rsp_ready low in stretches so that the hold rule of the result slot is exercised. The page values used include both legal and illegal numbers, among them writes at the same edge as an accepted request.

// File: rtl/pax_pkg.sv
package pax_pkg;
  localparam int LADDR_W = 16;
  localparam int GADDR_W = 23;
  localparam int PAGE_W  = 8;
  localparam int NUM_PG  = 4;
  localparam int SEL_W   = $clog2(NUM_PG);

  localparam logic [SEL_W-1:0] SEL_PROG = 2'd0;
  localparam logic [SEL_W-1:0] SEL_DFL  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_RAM  = 2'd2;
  localparam logic [SEL_W-1:0] SEL_GLB  = 2'd3;

  typedef enum logic [2:0] {
    WIN_REGS, WIN_DFL_PG, WIN_DFL_FIX, WIN_RAM_PG,
    WIN_RAM_FIX, WIN_PF_FIX, WIN_PF_PG, WIN_GLOBAL
  } win_e;

  typedef struct packed {
    logic [GADDR_W-1:0] gaddr;
    logic               illegal;
  } xl_res_t;
endpackage

// File: rtl/pax_page_regs.sv
module pax_page_regs
  import pax_pkg::*;
#(
  parameter int W = PAGE_W,
  parameter int N = NUM_PG,
  parameter logic [N*W-1:0] RST_VALS = {8'h00, 8'hFD, 8'h00, 8'hFE},
  parameter logic [N*W-1:0] WR_MASK  = {8'h7F, 8'hFF, 8'hFF, 8'hFF}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [$clog2(N)-1:0] wr_sel,
  input  logic [W-1:0]         wr_data,
  input  logic [$clog2(N)-1:0] rd_sel,
  output logic [W-1:0]         rd_data,
  output logic [N*W-1:0]       pages
);
  logic [W-1:0] pg_q [N];

  for (genvar i = 0; i < N; i++) begin : g_pg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pg_q[i] <= RST_VALS[i*W +: W];
      end else if (wr_en && (wr_sel == i[$clog2(N)-1:0])) begin
        pg_q[i] <= wr_data & WR_MASK[i*W +: W];
      end
    end
    assign pages[i*W +: W] = pg_q[i];
  end

  assign rd_data = pg_q[rd_sel];
endmodule

// File: rtl/pax_window_dec.sv
module pax_window_dec
  import pax_pkg::*;
#(
  parameter int LW = LADDR_W,
  parameter int GW = GADDR_W,
  parameter int PW = PAGE_W,
  parameter logic [PW-1:0] PF_MIN  = 8'hF8,
  parameter logic [PW-1:0] DFL_MAX = 8'h07,
  parameter logic [PW-1:0] RAM_MIN = 8'hFE
) (
  input  logic [LW-1:0] laddr,
  input  logic          glob,
  input  logic [PW-1:0] pg_prog,
  input  logic [PW-1:0] pg_dfl,
  input  logic [PW-1:0] pg_ram,
  input  logic [PW-1:0] pg_glb,
  output win_e          win,
  output xl_res_t       res
);
  localparam logic [GW-1:0] DFL_BASE  = 23'h10_0000;
  localparam logic [GW-1:0] DFL_FIXB  = 23'h10_1C00;
  localparam logic [GW-1:0] RAMF_BASE = 23'h0F_E000;
  localparam logic [GW-1:0] PFF_BASE  = 23'h7F_0000;

  always_comb begin
    if (glob)                     win = WIN_GLOBAL;
    else if (laddr < 16'h0800)    win = WIN_REGS;
    else if (laddr < 16'h0C00)    win = WIN_DFL_PG;
    else if (laddr < 16'h1000)    win = WIN_DFL_FIX;
    else if (laddr < 16'h2000)    win = WIN_RAM_PG;
    else if (laddr < 16'h4000)    win = WIN_RAM_FIX;
    else if (laddr[15:14] == 2'b10) win = WIN_PF_PG;
    else                          win = WIN_PF_FIX;
  end

  always_comb begin
    res = '0;
    unique case (win)
      WIN_GLOBAL:  res.gaddr = {pg_glb[6:0], laddr};
      WIN_REGS:    res.gaddr = {{(GW-LW){1'b0}}, laddr};
      WIN_DFL_PG: begin
        res.gaddr   = DFL_BASE | {{(GW-PW-10){1'b0}}, pg_dfl, laddr[9:0]};
        res.illegal = (pg_dfl > DFL_MAX);
      end
      WIN_DFL_FIX: res.gaddr = DFL_FIXB | {{(GW-10){1'b0}}, laddr[9:0]};
      WIN_RAM_PG: begin
        res.gaddr   = {{(GW-PW-12){1'b0}}, pg_ram, laddr[11:0]};
        res.illegal = (pg_ram < RAM_MIN);
      end
      WIN_RAM_FIX: res.gaddr = RAMF_BASE | {{(GW-13){1'b0}}, laddr[12:0]};
      WIN_PF_PG: begin
        res.gaddr   = {1'b1, pg_prog, laddr[13:0]};
        res.illegal = (pg_prog < PF_MIN);
      end
      default:     res.gaddr = PFF_BASE | {{(GW-LW){1'b0}}, laddr};
    endcase
  end
endmodule

// File: rtl/pax_rsp_stage.sv
module pax_rsp_stage
  import pax_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  output logic    in_ready,
  input  xl_res_t in_data,
  output logic    out_valid,
  input  logic    out_ready,
  output xl_res_t out_data
);
  logic    v_q;
  xl_res_t d_q;

  assign in_ready = !v_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      d_q <= '0;
    end else if (in_ready) begin
      v_q <= in_valid;
      if (in_valid) d_q <= in_data;
    end
  end

  assign out_valid = v_q;
  assign out_data  = d_q;
endmodule

// File: rtl/paged_addr_xlate.sv
module paged_addr_xlate
  import pax_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [15:0] req_laddr,
  input  logic        req_global,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [22:0] rsp_gaddr,
  output logic        rsp_illegal,
  input  logic        reg_wr_en,
  input  logic [1:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  input  logic [1:0]  reg_rd_sel,
  output logic [7:0]  reg_rdata
);
  logic [NUM_PG*PAGE_W-1:0] pages;
  logic [PAGE_W-1:0] pg_prog, pg_dfl, pg_ram, pg_glb;
  win_e    win;
  xl_res_t xl, rsp_d;

  pax_page_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_sel(reg_sel),
    .wr_data(reg_wdata), .rd_sel(reg_rd_sel), .rd_data(reg_rdata),
    .pages(pages)
  );

  assign pg_prog = pages[SEL_PROG*PAGE_W +: PAGE_W];
  assign pg_dfl  = pages[SEL_DFL*PAGE_W  +: PAGE_W];
  assign pg_ram  = pages[SEL_RAM*PAGE_W  +: PAGE_W];
  assign pg_glb  = pages[SEL_GLB*PAGE_W  +: PAGE_W];

  pax_window_dec u_dec (
    .laddr(req_laddr), .glob(req_global), .pg_prog(pg_prog), .pg_dfl(pg_dfl),
    .pg_ram(pg_ram), .pg_glb(pg_glb), .win(win), .res(xl)
  );

  pax_rsp_stage u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_ready(req_ready),
    .in_data(xl), .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(rsp_d)
  );

  assign rsp_gaddr   = rsp_d.gaddr;
  assign rsp_illegal = rsp_d.illegal;
endmodule

// File: rtl/paged_addr_xlate_chk.sv
module paged_addr_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [15:0] req_laddr,
  input logic        req_global,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [22:0] rsp_gaddr,
  input logic        rsp_illegal,
  input logic [1:0]  reg_rd_sel,
  input logic [7:0]  reg_rdata,
  input logic [7:0]  pg_prog,
  input logic [7:0]  pg_ram,
  input logic [7:0]  pg_glb
);
  logic acc;
  assign acc = req_valid && req_ready;

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid); // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_gaddr) && $stable(rsp_illegal))); // R11
  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R11
  AST_GLB_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_sel == 2'd3) |-> (reg_rdata[7] == 1'b0)); // R9
  AST_GLOBAL_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_global) |=> (rsp_gaddr == {$past(pg_glb[6:0]), $past(req_laddr)} && !rsp_illegal)); // R8
  AST_RAM_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_global && req_laddr[15:12] == 4'h1) |=> (rsp_illegal == ($past(pg_ram) < 8'hFE))); // R5
  AST_PF_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_global && req_laddr[15:14] == 2'b10) |=>
      (rsp_gaddr[22] && rsp_illegal == ($past(pg_prog) < 8'hF8))); // R3
endmodule

bind paged_addr_xlate paged_addr_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_laddr(req_laddr), .req_global(req_global), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_gaddr(rsp_gaddr), .rsp_illegal(rsp_illegal),
  .reg_rd_sel(reg_rd_sel), .reg_rdata(reg_rdata), .pg_prog(pg_prog),
  .pg_ram(pg_ram), .pg_glb(pg_glb)
);

// File: tb/paged_addr_xlate_tb_top.sv
`timescale 1ns/1ps
module paged_addr_xlate_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic d_valid, d_glob, d_rready, d_wr;
  logic [15:0] d_addr;
  logic [1:0] d_sel, d_rsel;
  logic [7:0] d_wdata;
  logic req_ready, rsp_valid, rsp_illegal;
  logic [22:0] rsp_gaddr;
  logic [7:0] reg_rdata;

  paged_addr_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(d_valid), .req_ready(req_ready),
    .req_laddr(d_addr), .req_global(d_glob), .rsp_valid(rsp_valid),
    .rsp_ready(d_rready), .rsp_gaddr(rsp_gaddr), .rsp_illegal(rsp_illegal),
    .reg_wr_en(d_wr), .reg_sel(d_sel), .reg_wdata(d_wdata),
    .reg_rd_sel(d_rsel), .reg_rdata(reg_rdata)
  );

  int n_vec = 0, n_bad = 0;
  int mp[4];
  bit m_valid;
  int m_gaddr;
  bit m_ill;
  string m_tag;
  bit done = 0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(int a, bit g);
    if (g) return "R8";
    if (a < 'h800) return "R7";
    if (a < 'h1000) return "R4";
    if (a < 'h2000) return "R5";
    if (a < 'h4000) return "R6";
    if (a >= 'h8000 && a < 'hC000) return "R3";
    return "R2";
  endfunction

  task automatic xlate(input int a, input bit g, output int ga, output bit ill);
    ill = 0;
    if (g) ga = (mp[3] % 128) * 65536 + a;
    else if (a < 'h800) ga = a;
    else if (a < 'hC00) begin ga = 'h100000 + mp[1] * 1024 + a % 1024; ill = mp[1] > 7; end
    else if (a < 'h1000) ga = 'h101C00 + a % 1024;
    else if (a < 'h2000) begin ga = mp[2] * 4096 + a % 4096; ill = mp[2] < 'hFE; end
    else if (a < 'h4000) ga = 'hFE000 + (a - 'h2000);
    else if (a >= 'h8000 && a < 'hC000) begin
      ga = 'h400000 + mp[0] * 16384 + a % 16384; ill = mp[0] < 'hF8;
    end else ga = 'h7F0000 + a;
    ga = ga % (1 << 23);
  endtask

  // one cycle: inputs already driven; model the edge, then check at negedge
  task automatic tick(string rtag);
    bit acc;
    int ga; bit il;
    @(posedge clk);
    acc = d_valid && (!m_valid || d_rready);
    if (acc) begin
      xlate(d_addr, d_glob, ga, il);
      m_valid = 1; m_gaddr = ga; m_ill = il; m_tag = tag_of(d_addr, d_glob);
    end else if (d_rready) m_valid = 0;
    if (d_wr) mp[d_sel] = (d_sel == 2'd3) ? (d_wdata % 128) : d_wdata;
    @(negedge clk);
    chk(req_ready == (!m_valid || d_rready), "R11", "req_ready", req_ready, !m_valid || d_rready);
    chk(rsp_valid == m_valid, "R10", "rsp_valid", rsp_valid, m_valid);
    if (m_valid && rsp_valid) begin
      chk(rsp_gaddr == m_gaddr[22:0], m_tag, "rsp_gaddr", rsp_gaddr, m_gaddr);
      chk(rsp_illegal == m_ill, m_tag, "rsp_illegal", rsp_illegal, m_ill);
    end
    chk(reg_rdata == mp[d_rsel][7:0], rtag, "reg_rdata", reg_rdata, mp[d_rsel]);
  endtask

  task automatic go(bit v, int a, bit g, bit rr, bit w, int s, int wd, int rs, string rtag);
    d_valid = v; d_addr = a[15:0]; d_glob = g; d_rready = rr;
    d_wr = w; d_sel = s[1:0]; d_wdata = wd[7:0]; d_rsel = rs[1:0];
    tick(rtag);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int addrs[16] = '{'h0000, 'h07FF, 'h0800, 'h0BFF, 'h0C00, 'h0FFF, 'h1000, 'h1FFF,
                      'h2000, 'h3FFF, 'h4000, 'h7FFF, 'h8000, 'hBFFF, 'hC000, 'hFFFF};
    rst_n = 0;
    d_valid = 0; d_addr = 0; d_glob = 0; d_rready = 1; d_wr = 0; d_sel = 0; d_wdata = 0; d_rsel = 0;
    mp[0] = 'hFE; mp[1] = 0; mp[2] = 'hFD; mp[3] = 0;
    m_valid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk(rsp_valid == 0, "R1", "rsp_valid after reset", rsp_valid, 0);
    // R1 reset values via read port
    for (int s = 0; s < 4; s++) go(0, 0, 0, 1, 0, 0, 0, s, "R1");
    // R5 trap before RAM page setup
    go(1, 'h1234, 0, 1, 0, 0, 0, 2, "R1");
    go(0, 0, 0, 1, 0, 0, 0, 2, "R1");
    // R9 global MSB ignored
    go(0, 0, 0, 1, 1, 3, 'hFF, 3, "R9");
    go(0, 0, 0, 1, 0, 0, 0, 3, "R9");
    // R10 same-edge write not seen by request: RAM page to 0xFE with access
    go(1, 'h1800, 0, 1, 1, 2, 'hFE, 2, "R9");
    go(1, 'h1800, 0, 1, 0, 0, 0, 2, "R9");
    // sweep all windows with legal and illegal pages
    for (int k = 0; k < 4; k++) begin
      int pv[4] = '{'hFC, 'h03, 'hFF, 'h2A};
      int pi[4] = '{'hF7, 'h08, 'hFD, 'h55};
      for (int s = 0; s < 3; s++) go(0, 0, 0, 1, 1, s, (k % 2) ? pi[s] : pv[s], s, "R9");
      go(0, 0, 0, 1, 1, 3, pv[3] + k, 3, "R9");
      for (int i = 0; i < 16; i++) go(1, addrs[i], 0, 1, 0, 0, 0, i % 4, "R9");
      for (int i = 0; i < 4; i++) go(1, addrs[i * 4 + 1], 1, 1, 0, 0, 0, 3, "R9");
    end
    // R11 stall: hold result under back-pressure
    go(1, 'h8123, 0, 0, 0, 0, 0, 0, "R9");
    for (int i = 0; i < 5; i++) go(1, 'h4000 + i, 0, 0, 0, 0, 0, 0, "R9");
    go(1, 'h4444, 0, 1, 0, 0, 0, 0, "R9");
    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom;
      int wd = $urandom_range(0, 255);
      if ($urandom_range(0, 3) == 0) wd = 'hF0 + $urandom_range(0, 15);
      go(r[0] | r[1], $urandom_range(0, 'hFFFF), r[2] & r[3] & r[4], r[5] | r[6],
         r[7] & r[8], r[10:9], wd, r[12:11], "R9");
    end
    go(0, 0, 0, 1, 0, 0, 0, 0, "R9");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule